// File: doc/BRIEF.md
# RTC Alarm Match Comparator

This block holds six alarm bytes and compares them with the running time fields of a real-time clock. The fields are seconds, minutes, hours, date, month and weekday. Bit 7 of each alarm byte selects whether that field takes part in the comparison. Bits 6:0 of the alarm byte use the same encoding as the matching time byte. The year never takes part.

The comparison is made only when the one-second update strobe is high, after the clock counter has settled its fields. The alarm flag rises when a match begins. It then stays high until software pulses the clear input. A match that lasts over several strobes counts as one event, so it cannot set the flag again.

Software writes and reads the alarm bytes through a small indexed register port. Index 0 is seconds, 1 is minutes, 2 is hours, 3 is date, 4 is month and 5 is weekday. The time bus packs field k into bits [8k+7:8k], in the same order.

Top module: `rtc_alarm_match`

## Requirements
- R1: A write with `regWrEn` high at index 0 to 5 stores the full 8-bit byte, enable bit included, at the clock edge. `regRdData` returns the stored byte combinationally for the index on `regAddr`.
- R2: At index 6 or 7, writes change no stored byte and reads return 0.
- R3: While `rstN` is low, all six alarm bytes read 0 and `alarmFlag` is 0.
- R4: On a strobe where at least one field is enabled, every enabled field's bits 6:0 equal the time field's bits 6:0, and the previous strobe had no match, `alarmFlag` is 1 from the next cycle on.
- R5: A field whose bit 7 is 0 has no effect on the match result.
- R6: When no alarm byte has bit 7 set, `alarmFlag` never rises, whatever the time fields hold.
- R7: When `tickStrobe` is low, `alarmFlag` does not rise, even if the fields match.
- R8: Once set, `alarmFlag` stays 1 until a cycle with `flagClear` high. It is 0 in the cycle after that clear, unless a new match event occurs in the same cycle.
- R9: A match that is already true on the previous strobe does not set the flag again after a clear. The match must first be false on some strobe.
- R10: A new match event and `flagClear` in the same cycle leave `alarmFlag` at 1.
- R11: Bit 7 of each time field is ignored by the comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Alarm byte write enable |
| regAddr | input | 3 | Alarm byte index for both write and read |
| regWrData | input | 8 | Byte to write |
| regRdData | output | 8 | Stored byte at `regAddr`, or 0 when the index is out of range |
| timeFields | input | 48 | Current time fields, field k in bits [8k+7:8k] |
| tickStrobe | input | 1 | One-second update strobe; the comparison happens only when it is high |
| flagClear | input | 1 | Clears the alarm flag |
| alarmFlag | output | 1 | Alarm flag, held until cleared |

## Verification
The random stimulus keeps alarm and time values in a narrow range, so full matches happen often. It also picks random enable masks and random bit-7 noise on the time bus. Together these show whether disabled fields, masked top bits and the edge-only event rule are handled apart. Directed runs cover the following cases:
- all fields disabled while the time equals the alarm values, which tells R6 apart from R4;
- a matching time held without a strobe (R7);
- a match that persists across a clear (R9);
- a new event that coincides with a clear (R10);
- writes and reads at the unused indices (R2).

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int FIELD_COUNT = 6;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = $clog2(FIELD_COUNT + 1);
  localparam int TIME_W = FIELD_COUNT * BYTE_W;
  localparam int VAL_W = BYTE_W - 1;

  typedef struct packed {
    logic [FIELD_COUNT-1:0] wrSel;
    logic evalTick;
  } alarm_ctrl_t;
endpackage

// File: rtl/alarm_match_dp.sv
module alarm_match_dp
  import rtc_alarm_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  alarm_ctrl_t              ctrl,
  input  logic [BYTE_W-1:0]        wrData,
  input  logic [ADDR_W-1:0]        rdIdx,
  input  logic [TIME_W-1:0]        timeFields,
  output logic [BYTE_W-1:0]        rdData,
  output logic                     matchNow,
  output logic                     matchPrev
);
  logic [BYTE_W-1:0] alarmReg [FIELD_COUNT];
  logic [FIELD_COUNT-1:0] fieldOk;
  logic [FIELD_COUNT-1:0] enBits;

  for (genvar i = 0; i < FIELD_COUNT; i++) begin : g_field
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) alarmReg[i] <= '0;
      else if (ctrl.wrSel[i]) alarmReg[i] <= wrData;
    end
    assign enBits[i]  = alarmReg[i][BYTE_W-1];
    assign fieldOk[i] = !enBits[i] ||
                        (alarmReg[i][VAL_W-1:0] == timeFields[i*BYTE_W +: VAL_W]);
  end

  assign matchNow = (|enBits) && (&fieldOk);

  always_comb begin
    rdData = '0;
    for (int i = 0; i < FIELD_COUNT; i++)
      if (rdIdx == ADDR_W'(i)) rdData = alarmReg[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchPrev <= 1'b0;
    else if (ctrl.evalTick) matchPrev <= matchNow;
  end
endmodule

// File: rtl/alarm_match_ctrl.sv
module alarm_match_ctrl
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              tickStrobe,
  input  logic              flagClear,
  input  logic              matchNow,
  input  logic              matchPrev,
  output alarm_ctrl_t       ctrl,
  output logic              alarmFlag
);
  logic matchRise;

  for (genvar i = 0; i < FIELD_COUNT; i++) begin : g_dec
    assign ctrl.wrSel[i] = regWrEn && (regAddr == ADDR_W'(i));
  end
  assign ctrl.evalTick = tickStrobe;

  assign matchRise = tickStrobe && matchNow && !matchPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) alarmFlag <= 1'b0;
    else if (matchRise) alarmFlag <= 1'b1;
    else if (flagClear) alarmFlag <= 1'b0;
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [47:0]       timeFields,
  input  logic              tickStrobe,
  input  logic              flagClear,
  output logic              alarmFlag
);
  alarm_ctrl_t ctrl;
  logic matchNow;
  logic matchPrev;

  alarm_match_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .tickStrobe(tickStrobe), .flagClear(flagClear),
    .matchNow(matchNow), .matchPrev(matchPrev),
    .ctrl(ctrl), .alarmFlag(alarmFlag)
  );

  alarm_match_dp u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(regWrData),
    .rdIdx(regAddr), .timeFields(timeFields), .rdData(regRdData),
    .matchNow(matchNow), .matchPrev(matchPrev)
  );
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] regAddr,
  input logic [7:0] regRdData,
  input logic       tickStrobe,
  input logic       flagClear,
  input logic       alarmFlag,
  input logic       matchNow,
  input logic       matchPrev
);
  p_unused_idx_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > 3'd5) |-> (regRdData == 8'd0));

  p_set_on_event_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tickStrobe && matchNow && !matchPrev) |=> alarmFlag);

  p_no_tick_no_rise_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!tickStrobe && !alarmFlag) |=> !alarmFlag);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !flagClear) |=> alarmFlag);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear && !tickStrobe) |=> !alarmFlag);

  p_once_per_event_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tickStrobe && matchPrev && !alarmFlag) |=> !alarmFlag);
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdData(regRdData),
  .tickStrobe(tickStrobe), .flagClear(flagClear), .alarmFlag(alarmFlag),
  .matchNow(matchNow), .matchPrev(matchPrev)
);

// File: tb/rtc_alarm_match_tb.sv
module rtc_alarm_match_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [47:0] timeFields = '0;
  logic        tickStrobe = 1'b0;
  logic        flagClear = 1'b0;
  logic        alarmFlag;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  logic [7:0] mReg [6];
  logic mFlag = 1'b0;
  logic mPrev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_match u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .timeFields(timeFields),
    .tickStrobe(tickStrobe), .flagClear(flagClear), .alarmFlag(alarmFlag)
  );

  function automatic logic modelMatch(input logic [47:0] t);
    logic anyEn = 1'b0;
    logic ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (mReg[i][7]) begin
        anyEn = 1'b1;
        if (mReg[i][6:0] != t[i*8 +: 7]) ok = 1'b0;
      end
    end
    return anyEn && ok;
  endfunction

  function automatic logic [7:0] modelRead(input logic [2:0] a);
    return (a < 3'd6) ? mReg[a] : 8'd0;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clock cycle: drive at negedge, check the read path, step the model, check the flag.
  task automatic step(input string tag, input logic we, input logic [2:0] a,
                      input logic [7:0] d, input logic [47:0] t,
                      input logic tk, input logic clr);
    logic m;
    logic rise;
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d; timeFields = t;
    tickStrobe = tk; flagClear = clr;
    #1;
    check("R1/R2 read", regRdData, modelRead(a));
    m = modelMatch(t);
    rise = tk && m && !mPrev;
    if (rise) mFlag = 1'b1;
    else if (clr) mFlag = 1'b0;
    if (tk) mPrev = m;
    if (we && a < 3'd6) mReg[a] = d;
    @(posedge clk);
    #1;
    check(tag, {7'd0, alarmFlag}, {7'd0, mFlag});
  endtask

  function automatic logic [47:0] packT(input logic [6:0] v);
    logic [47:0] r;
    for (int i = 0; i < 6; i++) r[i*8 +: 8] = {1'b0, v};
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [47:0] t;
    void'($urandom(32'd4242));
    for (int i = 0; i < 6; i++) mReg[i] = 8'd0;
    #(CLK_PERIOD * 3);
    // R3 reset state
    for (int a = 0; a < 6; a++) begin
      regAddr = 3'(a); #1;
      check("R3 reset byte", regRdData, 8'd0);
    end
    check("R3 reset flag", {7'd0, alarmFlag}, 8'd0);
    @(negedge clk); rstN = 1'b1;

    // R1 write/read of every byte, R2 unused indices
    for (int a = 0; a < 6; a++) step("R1", 1'b1, 3'(a), 8'h35 + 8'(a), '0, 1'b0, 1'b0);
    step("R2 write idx6", 1'b1, 3'd6, 8'hFF, '0, 1'b0, 1'b0);
    step("R2 write idx7", 1'b1, 3'd7, 8'hFF, '0, 1'b0, 1'b0);
    for (int a = 0; a < 8; a++) step("R2 readback", 1'b0, 3'(a), '0, '0, 1'b0, 1'b0);

    // R6: all disabled, time equals alarm values
    for (int a = 0; a < 6; a++) step("R6 setup", 1'b1, 3'(a), 8'h05, '0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) step("R6 no enable", 1'b0, 3'd0, '0, packT(7'd5), 1'b1, 1'b0);

    // Enable seconds and hours only (value 5); others stay disabled
    step("R5 setup", 1'b1, 3'd0, 8'h85, '0, 1'b0, 1'b0);
    step("R5 setup", 1'b1, 3'd2, 8'h85, '0, 1'b0, 1'b0);
    t = packT(7'd9); t[7:0] = 8'h85; t[23:16] = 8'h05;  // R11: bit 7 noise on seconds
    step("R7 match no tick", 1'b0, 3'd0, '0, t, 1'b0, 1'b0);
    step("R7 match no tick", 1'b0, 3'd0, '0, t, 1'b0, 1'b0);
    step("R4 R5 R11 event", 1'b0, 3'd0, '0, t, 1'b1, 1'b0);
    step("R8 hold", 1'b0, 3'd0, '0, t, 1'b1, 1'b0);
    step("R8 clear", 1'b0, 3'd0, '0, t, 1'b0, 1'b1);
    step("R9 persisting match", 1'b0, 3'd0, '0, t, 1'b1, 1'b0);
    step("R9 persisting match", 1'b0, 3'd0, '0, t, 1'b1, 1'b0);
    step("R9 match breaks", 1'b0, 3'd0, '0, packT(7'd1), 1'b1, 1'b0);
    step("R10 event with clear", 1'b0, 3'd0, '0, t, 1'b1, 1'b1);
    step("R8 clear again", 1'b0, 3'd0, '0, t, 1'b0, 1'b1);

    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [47:0] rt;
      logic [2:0] ra;
      logic [7:0] rd;
      for (int i = 0; i < 6; i++)
        rt[i*8 +: 8] = {1'($urandom_range(0, 1)), 7'($urandom_range(0, 2))};
      ra = 3'($urandom_range(0, 7));
      rd = {1'($urandom_range(0, 2) == 0), 7'($urandom_range(0, 2))};
      step("R4 R5 R8 R9 R11 random", $urandom_range(0, 5) == 0, ra, rd, rt,
           $urandom_range(0, 2) == 0, $urandom_range(0, 7) == 0);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule